// File: doc/BRIEF.md
# Bit-Per-Way Pseudo-LRU Victim Selector

This block holds the replacement state of an N-way set-associative cache. Every set keeps one "recently used" flag per way. When the cache reports a hit or a fill, it presents the set and the way, and that way's flag is raised. When raising the flag would leave every flag of the set high, the set is cleared except for that way. A cache controller that needs to evict from a set puts the set number on the query port. The block then returns, in the same cycle, a way whose flag is low.

When more than one way has a low flag, a free-running linear feedback shift register chooses among them. The register is reloaded with a fixed seed on every reset, so the same run of accesses after reset always gives the same run of victims. This makes replacement reproducible when a design is debugged. Tag storage, data storage and hit detection are left to the enclosing cache.

Top module: `mru_plru_repl`

## Requirements
- R1: While reset is asserted and after it is released, every flag of every set is 0 and the random register holds the seed 16'hACE1.
- R2: An access with `acc_valid` high raises flag `acc_way` of set `acc_set` at the next rising clock edge.
- R3: If raising that flag would make all flags of the set 1, the set instead becomes a vector with only flag `acc_way` set.
- R4: `vq_way` always names a way whose flag is 0 in set `vq_set`.
- R5: The victim search starts at way `lfsr[1:0]` (bit 0 of the register is the least significant bit of the start way). It steps upward through the way numbers, wrapping from WAYS-1 to 0, and returns the first way whose flag is 0.
- R6: The random register is a 16-bit Fibonacci shift register. Its next value is `{r[14:0], r[15]^r[13]^r[12]^r[10]}`. It advances on every rising edge outside reset. As a result, an identical access sequence after any reset gives identical victims.
- R7: A query and an access to the same set in the same cycle return the victim computed from the flags before that access.
- R8: An access to one set leaves the flags of every other set unchanged.
- R9: With `acc_valid` low, no flag changes, whatever the values of `acc_set` and `acc_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Hit or fill strobe |
| acc_set | input | 6 | Set index of the access |
| acc_way | input | 2 | Way that was hit or filled |
| vq_set | input | 6 | Set index for the victim query |
| vq_way | output | 2 | Combinational victim way for `vq_set` |

## Verification
The assertions check on every cycle that:
- the returned victim has a clear flag (R4);
- no set is ever left with all flags set (R3);
- an access raises its flag, and a saturating access collapses the set to one flag (R2, R3);
- an idle cycle leaves the state untouched (R9);
- the random register never locks at zero.

Other behaviour shows only in the bench's scenarios, where a scoreboard compares each victim against a model of the flags and the shift register:
- the exact choice among several clear ways (R5);
- same-cycle read-before-update ordering (R7);
- isolation between sets (R8);
- the identical replay of a long access stream after a second reset (R6).

// File: rtl/mru_plru_pkg.sv
package mru_plru_pkg;

    localparam int RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

    // Fibonacci feedback for x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] cur);
        return {cur[RND_W-2:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
    endfunction

endpackage

// File: rtl/mru_rnd_gen.sv
module mru_rnd_gen
    import mru_plru_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = RND_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd_q
);

    typedef struct packed {
        logic [RND_W-1:0] val;
    } rnd_state_t;

    rnd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = rnd_step(st_q.val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign rnd_q = st_q.val;

endmodule

// File: rtl/mru_row_update.sv
module mru_row_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  row_i,
    input  logic [WAY_W-1:0] way_i,
    output logic [WAYS-1:0]  row_o
);

    logic [WAYS-1:0] hot;
    logic [WAYS-1:0] merged;

    always_comb begin
        hot    = '0;
        hot[way_i] = 1'b1;
        merged = row_i | hot;
        if (&merged) begin
            row_o = hot;
        end else begin
            row_o = merged;
        end
    end

endmodule

// File: rtl/mru_victim_pick.sv
module mru_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  row_i,
    input  logic [WAY_W-1:0] start_i,
    output logic [WAY_W-1:0] way_o
);

    // Each candidate is the start way plus an offset, wrapping modulo WAYS.
    logic [WAYS-1:0][WAY_W-1:0] cand;
    logic [WAYS-1:0]            free;

    for (genvar g = 0; g < WAYS; g++) begin : g_cand
        assign cand[g] = start_i + WAY_W'(g);
        assign free[g] = ~row_i[cand[g]];
    end

    always_comb begin
        way_o = start_i;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (free[k]) begin
                way_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/mru_plru_repl.sv
module mru_plru_repl
    import mru_plru_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [$clog2(SETS)-1:0] acc_set,
    input  logic [$clog2(WAYS)-1:0] acc_way,
    input  logic [$clog2(SETS)-1:0] vq_set,
    output logic [$clog2(WAYS)-1:0] vq_way
);

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] bits;
    } repl_state_t;

    repl_state_t st_d, st_q;

    logic [WAYS-1:0]     acc_row;
    logic [WAYS-1:0]     acc_row_nxt;
    logic [WAYS-1:0]     vq_row;
    logic [RND_W-1:0]    rnd_q;
    logic [SETS*WAYS-1:0] state_flat;

    mru_rnd_gen #(
        .SEED (RND_SEED)
    ) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_q (rnd_q)
    );

    assign acc_row = st_q.bits[acc_set];
    assign vq_row  = st_q.bits[vq_set];

    mru_row_update #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_upd (
        .row_i (acc_row),
        .way_i (acc_way),
        .row_o (acc_row_nxt)
    );

    mru_victim_pick #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_pick (
        .row_i   (vq_row),
        .start_i (rnd_q[WAY_W-1:0]),
        .way_o   (vq_way)
    );

    always_comb begin
        st_d = st_q;
        if (acc_valid) begin
            st_d.bits[acc_set] = acc_row_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_flat = st_q.bits;

endmodule

// File: rtl/mru_plru_chk.sv
module mru_plru_chk #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic [$clog2(SETS)-1:0] acc_set,
    input logic [$clog2(WAYS)-1:0] acc_way,
    input logic [$clog2(WAYS)-1:0] vq_way,
    input logic [WAYS-1:0]         vq_row,
    input logic [WAYS-1:0]         acc_row,
    input logic [SETS*WAYS-1:0]    state_flat,
    input logic [15:0]             rnd_q
);

    // R4: the chosen way is one whose flag is clear
    p_victim_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vq_row[vq_way]);

    // R3: a stored set never has every flag raised
    p_never_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&vq_row));

    // R2: the accessed flag is high after the edge
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> state_flat[int'($past(acc_set)) * WAYS + int'($past(acc_way))]);

    // R3: a saturating access leaves only the accessed flag
    p_collapse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ((acc_row | (WAYS'(1) << acc_way)) == {WAYS{1'b1}}))
        |=> (state_flat[int'($past(acc_set)) * WAYS +: WAYS] == (WAYS'(1) << $past(acc_way))));

    // R9: idle cycles keep the whole state
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(state_flat));

    // R6: the shift register never locks at zero
    p_rnd_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q != 16'h0000);

endmodule

bind mru_plru_repl mru_plru_chk #(
    .SETS (SETS),
    .WAYS (WAYS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_way    (acc_way),
    .vq_way     (vq_way),
    .vq_row     (vq_row),
    .acc_row    (acc_row),
    .state_flat (state_flat),
    .rnd_q      (rnd_q)
);

// File: tb/mru_plru_repl_tb.sv
module mru_plru_repl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_set = '0;
    logic [1:0] acc_way = '0;
    logic [5:0] vq_set = '0;
    logic [1:0] vq_way;

    always #4 clk = ~clk;

    mru_plru_repl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .vq_set    (vq_set),
        .vq_way    (vq_way)
    );

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sbq[$];
    logic [1:0] log_a[$];
    logic [1:0] log_b[$];
    int         rec_sel = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;

    logic [3:0]  mbits [64];
    logic [15:0] mrnd;

    function automatic logic [15:0] rstep(input logic [15:0] r);
        return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    endfunction

    function automatic logic [1:0] pick(input logic [3:0] row, input logic [15:0] r);
        for (int k = 0; k < 4; k++) begin
            automatic logic [1:0] w;
            w = r[1:0] + 2'(k);
            if (!row[w]) return w;
        end
        return 2'd0;
    endfunction

    function automatic logic [3:0] upd(input logic [3:0] row, input logic [1:0] w);
        automatic logic [3:0] h = 4'b0001 << w;
        if ((row | h) == 4'hF) return h;
        return row | h;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 64; s++) mbits[s] = 4'h0;
        mrnd = 16'hACE1;
    endtask

    // One cycle: drive at the falling edge, push the expected victim, advance the model.
    task automatic cycle(input logic av, input logic [5:0] as, input logic [1:0] aw,
                         input logic [5:0] qs, input string tag);
        sb_item_t it;
        acc_valid = av;
        acc_set   = as;
        acc_way   = aw;
        vq_set    = qs;
        it.exp = pick(mbits[qs], mrnd);
        it.tag = tag;
        sbq.push_back(it);
        if (av) mbits[as] = upd(mbits[as], aw);
        mrnd = rstep(mrnd);
        @(negedge clk);
    endtask

    task automatic do_reset();
        sb_item_t it;
        rst_n     = 1'b0;
        acc_valid = 1'b0;
        model_reset();
        @(negedge clk);
        // R1: reset state, flags clear and seed loaded
        vq_set = 6'd9;
        it.exp = pick(4'h0, 16'hACE1);
        it.tag = "R1";
        sbq.push_back(it);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // Monitor: samples 2 ns after each falling edge, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() != 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                check(vq_way == it.exp, it.tag, vq_way, it.exp);
                if (rec_sel == 1) log_a.push_back(vq_way);
                if (rec_sel == 2) log_b.push_back(vq_way);
            end
        end
    end

    task automatic long_run();
        for (int i = 0; i < 300; i++) begin
            cycle(1'b1, 6'(i * 7), 2'((i * 3) ^ (i >> 2)), 6'(i * 5), "R4 R5");
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R7: query and access of set 3 together see the old flags
        cycle(1'b1, 6'd3, 2'd0, 6'd3, "R7");
        cycle(1'b1, 6'd3, 2'd1, 6'd3, "R2");
        cycle(1'b1, 6'd3, 2'd2, 6'd3, "R2");
        cycle(1'b0, 6'd0, 2'd0, 6'd3, "R2 only way 3 clear");
        // R3: filling the last way collapses the set to that way
        cycle(1'b1, 6'd3, 2'd3, 6'd3, "R3 R7");
        cycle(1'b0, 6'd0, 2'd0, 6'd3, "R3");
        // R8: activity in set 5 leaves set 3 alone
        cycle(1'b1, 6'd5, 2'd2, 6'd3, "R8");
        cycle(1'b1, 6'd5, 2'd0, 6'd3, "R8");
        cycle(1'b0, 6'd0, 2'd0, 6'd5, "R8 set 5");
        // R9: strobe low with a live set and way has no effect
        cycle(1'b0, 6'd3, 2'd0, 6'd3, "R9");
        cycle(1'b0, 6'd3, 2'd1, 6'd3, "R9");
        cycle(1'b0, 6'd3, 2'd2, 6'd3, "R9");
        // Another collapse on a different way and set
        cycle(1'b1, 6'd60, 2'd3, 6'd60, "R2");
        cycle(1'b1, 6'd60, 2'd2, 6'd60, "R2");
        cycle(1'b1, 6'd60, 2'd1, 6'd60, "R2");
        cycle(1'b1, 6'd60, 2'd0, 6'd60, "R3");
        cycle(1'b0, 6'd0, 2'd0, 6'd60, "R3");
        drain();

        // R6: identical stream after reset gives identical victims
        do_reset();
        rec_sel = 1;
        long_run();
        drain();
        rec_sel = 0;
        do_reset();
        drain();
        rec_sel = 2;
        long_run();
        drain();
        rec_sel = 0;
        check(log_a.size() == log_b.size(), "R6 replay length", log_b.size(), log_a.size());
        begin
            int mism = 0;
            for (int i = 0; i < log_a.size() && i < log_b.size(); i++) begin
                if (log_a[i] != log_b[i]) mism++;
            end
            check(mism == 0, "R6 replay match", mism, 0);
        end
        finish_up();
    end

endmodule